// File: doc/BRIEF.md
# Saturating PRBS Error Counter

This block counts bit errors that a PRBS monitor reports. The count is 16 bits wide and saturates instead of wrapping. The block counts only while the monitor is enabled and reports that it is synchronised. An alarm-simulation mode replaces error counting with a count of every second received bit. Software reads the value as two bytes from a shadow buffer, so the live counter can keep running while software reads a stable value.

A small state machine controls the buffer, with three states. In `TRACK`, which is mode 0, the buffer copies the live count on every cycle. In `FROZEN`, the buffer holds its value. The transition `TRACK -> FROZEN` fires on a rising edge of the software snapshot-request bit, and it also clears the live counter. The transition `FROZEN -> TRACK` fires when software reads the high byte, which also clears the request bit. In `LATCH`, which is mode 1, each one-second tick copies the count into the buffer and clears the counter. Raising the mode input causes `any -> LATCH`. Dropping the mode input in `LATCH` causes `LATCH -> TRACK`.

Top module: `prbs_err_counter`

## Requirements
- R1: After reset, both buffer bytes read 0, the request bit reads 0, the live count is 0 and the state is `TRACK`.
- R2: When alarm simulation is off, the count increases by one on each cycle where `err_stb`, `mon_en` and `prbs_sync` are all 1. If `mon_en` or `prbs_sync` is 0, errors are ignored.
- R3: The count stops at 16'hFFFF and holds that value while further errors arrive. It never wraps to 0.
- R4: When `alarm_sim` is 1, `mon_en` is 1 and `prbs_sync` is 1, the count increases on every second `bit_stb` and ignores `err_stb`. The 2nd, 4th and later strobes after `alarm_sim` rises each add one. Dropping `alarm_sim` restarts the pairing.
- R5: In `TRACK`, the buffer outputs show the live count with a delay of one cycle.
- R6: In `TRACK`, with `mode_sel`=0, a `snap_set` pulse while the request bit is 0 starts a snapshot. The bit goes to 1. The buffer keeps the count from before the clear. The live counter is cleared in the same cycle. The buffer then stays unchanged in `FROZEN`.
- R7: An `rd_hi` pulse clears the request bit and returns `FROZEN` to `TRACK`. Buffer updating resumes on the cycle after the read. If `rd_hi` and `snap_set` arrive together, the read wins and the bit reads 0.
- R8: In `LATCH`, each `sec_tick` copies the count into the buffer and clears the counter. Between ticks, the buffer holds its value.
- R9: If a countable event arrives in the same cycle as a clear (a snapshot edge or a tick), the count becomes 1 instead of 0.
- R10: `buf_lo` is bits 7..0 of the buffer and `buf_hi` is bits 15..8. `rd_lo` changes neither byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | PRBS monitor enable |
| prbs_sync | input | 1 | Monitor reports synchronous state |
| err_stb | input | 1 | One received bit was in error |
| bit_stb | input | 1 | One bit was received |
| alarm_sim | input | 1 | Alarm-simulation enable |
| sec_tick | input | 1 | One-second tick pulse |
| mode_sel | input | 1 | 0 = track/snapshot, 1 = latch on tick |
| snap_set | input | 1 | Software write of 1 to the request bit |
| rd_lo | input | 1 | Low byte read strobe |
| rd_hi | input | 1 | High byte read strobe |
| buf_lo | output | 8 | Buffered count, low byte |
| buf_hi | output | 8 | Buffered count, high byte |
| snap_bit | output | 1 | Request bit read-back |

## Verification
Error strobes are gated with every combination of enable and sync. This separates correct gating from counting on the strobe alone. Bit strobes are driven in alarm simulation with and without error strobes, and alarm simulation is switched off and on again. This shows the divide-by-two count, that errors are ignored, and that the pairing restarts. The capture paths are exercised with errors placed on the clear cycle, with snapshot and read in the same cycle, and with repeated ticks. A long error burst then drives the count past 16'hFFFF to show that it saturates.

// File: rtl/prbs_err_pkg.sv
package prbs_err_pkg;
    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_FROZEN = 2'd1,
        ST_LATCH  = 2'd2
    } cap_state_t;
endpackage

// File: rtl/prbs_err_ctrl.sv
module prbs_err_ctrl
    import prbs_err_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sel,
    input  logic       snap_set,
    input  logic       rd_hi,
    input  logic       sec_tick,
    output cap_state_t state,
    output logic       snap_q,
    output logic       clr_req,
    output logic       buf_load
);
    cap_state_t state_d;
    logic       set_eff;
    logic       snap_edge;

    assign set_eff   = snap_set && !rd_hi;
    assign snap_edge = (state == ST_TRACK) && !mode_sel && set_eff && !snap_q;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_TRACK:  state_d = mode_sel ? ST_LATCH : (snap_edge ? ST_FROZEN : ST_TRACK);
            ST_FROZEN: state_d = mode_sel ? ST_LATCH : (rd_hi ? ST_TRACK : ST_FROZEN);
            ST_LATCH:  state_d = mode_sel ? ST_LATCH : ST_TRACK;
            default:   state_d = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_TRACK;
            snap_q <= 1'b0;
        end else begin
            state <= state_d;
            if (rd_hi)        snap_q <= 1'b0;
            else if (set_eff) snap_q <= 1'b1;
        end
    end

    always_comb begin
        clr_req  = 1'b0;
        buf_load = 1'b0;
        unique case (state)
            ST_TRACK: begin
                buf_load = 1'b1;
                clr_req  = snap_edge;
            end
            ST_FROZEN: begin
                buf_load = 1'b0;
            end
            ST_LATCH: begin
                buf_load = sec_tick;
                clr_req  = sec_tick;
            end
            default: ;
        endcase
    end

    // R7: a high byte read always leaves the request bit at 0
    p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> !snap_q);

    // R6: the snapshot edge enters FROZEN with the bit set
    p_edge_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && !mode_sel && snap_set && !rd_hi && !snap_q)
        |=> (state == ST_FROZEN && snap_q));
endmodule

// File: rtl/prbs_err_count.sv
module prbs_err_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_en,
    input  logic             prbs_sync,
    input  logic             err_stb,
    input  logic             bit_stb,
    input  logic             alarm_sim,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic half_q;
    logic evt;
    logic gate;

    assign gate = mon_en && prbs_sync;
    assign evt  = gate && (alarm_sim ? (bit_stb && half_q) : err_stb);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (!alarm_sim)   half_q <= 1'b0;
            else if (bit_stb) half_q <= !half_q;

            if (clr)                         cnt_q <= evt ? CNT_W'(1) : '0;
            else if (evt && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the full count holds unless it is cleared
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

    // R9: a clear leaves at most one event counted
    p_clr_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q <= CNT_W'(1));

    // R4: pairing restarts whenever alarm simulation is off
    p_half_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_sim |=> !half_q);
endmodule

// File: rtl/prbs_err_counter.sv
module prbs_err_counter
    import prbs_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mon_en,
    input  logic                 prbs_sync,
    input  logic                 err_stb,
    input  logic                 bit_stb,
    input  logic                 alarm_sim,
    input  logic                 sec_tick,
    input  logic                 mode_sel,
    input  logic                 snap_set,
    input  logic                 rd_lo,
    input  logic                 rd_hi,
    output logic [CNT_W/2-1:0]   buf_lo,
    output logic [CNT_W/2-1:0]   buf_hi,
    output logic                 snap_bit
);
    localparam int HALF_W = CNT_W / 2;

    cap_state_t       state;
    logic             clr_req;
    logic             buf_load;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] buf_q;
    logic             rd_lo_unused;

    assign rd_lo_unused = rd_lo;

    prbs_err_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .snap_set (snap_set),
        .rd_hi    (rd_hi),
        .sec_tick (sec_tick),
        .state    (state),
        .snap_q   (snap_bit),
        .clr_req  (clr_req),
        .buf_load (buf_load)
    );

    prbs_err_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_en    (mon_en),
        .prbs_sync (prbs_sync),
        .err_stb   (err_stb),
        .bit_stb   (bit_stb),
        .alarm_sim (alarm_sim),
        .clr       (clr_req),
        .cnt_q     (cnt_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        buf_q <= '0;
        else if (buf_load) buf_q <= cnt_q;
    end

    assign buf_lo = buf_q[HALF_W-1:0];
    assign buf_hi = buf_q[CNT_W-1:HALF_W];

    // R6: the buffer holds while in FROZEN
    p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN) |=> $stable(buf_q));

    // R5: in TRACK the buffer takes the count seen one cycle earlier
    p_track_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK) |=> buf_q == $past(cnt_q));

    // R8: between ticks in LATCH the buffer holds
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && !sec_tick) |=> $stable(buf_q));
endmodule

// File: tb/tb_prbs_err_counter.sv
module tb_prbs_err_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_en = 0, prbs_sync = 0, err_stb = 0, bit_stb = 0, alarm_sim = 0;
    logic sec_tick = 0, mode_sel = 0, snap_set = 0, rd_lo = 0, rd_hi = 0;
    logic [7:0] buf_lo, buf_hi;
    logic snap_bit;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference model state
    int  m_cnt = 0, m_buf = 0;
    bit  m_snap = 0, m_half = 0;
    int  m_st = 0; // 0 track, 1 frozen, 2 latch

    prbs_err_counter dut (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .prbs_sync(prbs_sync),
        .err_stb(err_stb), .bit_stb(bit_stb), .alarm_sim(alarm_sim),
        .sec_tick(sec_tick), .mode_sel(mode_sel), .snap_set(snap_set),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .buf_lo(buf_lo), .buf_hi(buf_hi),
        .snap_bit(snap_bit)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_buf = 0; m_snap = 0; m_half = 0; m_st = 0;
        end else begin
            bit inc, setw, edge_ev, clr;
            int nst;
            inc = mon_en && prbs_sync && (alarm_sim ? (bit_stb && m_half) : err_stb);
            setw = snap_set && !rd_hi;
            edge_ev = (m_st == 0) && !mode_sel && setw && !m_snap;
            clr = edge_ev || (m_st == 2 && sec_tick);
            if (m_st == 0 || (m_st == 2 && sec_tick)) m_buf = m_cnt;
            if (mode_sel) nst = 2;
            else if (m_st == 2) nst = 0;
            else if (m_st == 0) nst = edge_ev ? 1 : 0;
            else nst = rd_hi ? 0 : 1;
            m_st = nst;
            if (rd_hi) m_snap = 0; else if (setw) m_snap = 1;
            if (!alarm_sim) m_half = 0; else if (bit_stb) m_half = !m_half;
            if (clr) m_cnt = inc ? 1 : 0;
            else if (inc && m_cnt != 65535) m_cnt = m_cnt + 1;
        end
        #3;
        checks++;
        if ({buf_hi, buf_lo} !== 16'(m_buf) || snap_bit !== m_snap) begin
            errors++;
            $display("FAIL %s: buf=%h snap=%b expected buf=%h snap=%b at %0t",
                     cur_req, {buf_hi, buf_lo}, snap_bit, 16'(m_buf), m_snap, $time);
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_idle();
        err_stb = 0; bit_stb = 0; sec_tick = 0; snap_set = 0; rd_lo = 0; rd_hi = 0;
    endtask

    task automatic errs(int n);
        for (int i = 0; i < n; i++) begin
            err_stb = 1; step(); err_stb = 0; step();
        end
    endtask

    initial begin
        step(3);
        cur_req = "R1";
        checks++;
        if ({buf_hi, buf_lo} !== 16'h0 || snap_bit !== 1'b0) begin
            errors++;
            $display("FAIL R1: buf=%h snap=%b expected 0000/0", {buf_hi, buf_lo}, snap_bit);
        end
        rst_n = 1; step(2);

        // R2: gating combinations
        cur_req = "R2";
        for (int c = 0; c < 4; c++) begin
            mon_en = c[0]; prbs_sync = c[1]; errs(3);
        end
        mon_en = 1; prbs_sync = 1;
        cur_req = "R5"; errs(5); step(3);

        // R10: low byte read has no effect
        cur_req = "R10"; rd_lo = 1; step(2); rd_lo = 0; step(2);

        // R6 with R9 coinciding error
        cur_req = "R6"; errs(4);
        snap_set = 1; err_stb = 1; step(); pulse_idle();
        cur_req = "R9"; step();
        cur_req = "R6"; errs(6); step(2);
        snap_set = 1; step(); snap_set = 0; step(2); // already set: no new edge
        cur_req = "R7"; rd_hi = 1; step(); rd_hi = 0; step(3);
        snap_set = 1; rd_hi = 1; step(); pulse_idle(); step(2);
        errs(3);
        snap_set = 1; step(); snap_set = 0; errs(2);
        rd_hi = 1; step(); rd_hi = 0; step(3);

        // R4 alarm simulation
        cur_req = "R4"; alarm_sim = 1;
        for (int i = 0; i < 9; i++) begin
            bit_stb = 1; err_stb = i[0]; step(); pulse_idle(); step();
        end
        alarm_sim = 0; step();
        alarm_sim = 1;
        for (int i = 0; i < 3; i++) begin bit_stb = 1; step(); end
        pulse_idle(); alarm_sim = 0; step(3);

        // R8 latch mode
        cur_req = "R8"; mode_sel = 1; step(2);
        errs(7); sec_tick = 1; step(); sec_tick = 0; errs(2); step(3);
        cur_req = "R9"; err_stb = 1; sec_tick = 1; step(); pulse_idle(); step(2);
        cur_req = "R8"; errs(3); sec_tick = 1; step(); sec_tick = 0; step(3);
        mode_sel = 0; step(3);

        // R3 saturation
        cur_req = "R3"; err_stb = 1; step(65545); err_stb = 0; step(4);
        checks++;
        if ({buf_hi, buf_lo} !== 16'hFFFF) begin
            errors++;
            $display("FAIL R3: buf=%h expected ffff", {buf_hi, buf_lo});
        end
        done = 1;
        step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule